// File: doc/BRIEF.md
# Indexed Data Memory Address Generator

This block is a single-port data memory of 1024 words by 16 bits together with the logic that forms its addresses. Each cycle it takes at most one access command, either a read or a write. The command's mode selects the effective address. In direct mode the address comes from the command. In indirect mode a pointer word is fetched from memory first. In the indexed modes the address is the current value of one of sixteen index registers, which can then be changed after the access.

After the access, an index register can be stepped by one, or moved up or down by a per-register step constant. All index arithmetic wraps modulo the memory depth. A separate setup port loads index values, step constants and a limit address. Every completed access compares its effective address with the limit and registers the result as a condition flag, for use by branch logic.

Top module: `dmem_agen`

## Requirements
- R1: After reset, `busy_o`, `rvalid_o`, `cmp_hit_o` and `acc_addr_o` are 0, and all index registers, step constants and the limit are 0.
- R2: A read command completing at a clock edge presents the addressed word on `rdata_o` with `rvalid_o`=1 after that same edge, which is a latency of one cycle.
- R3: At most one access completes per cycle. A write stores `cmd_wdata_i` and leaves `rvalid_o`=0. Read commands may issue back to back.
- R4: `cmd_mode_i` encodes the mode as follows: 0 direct (the address is `cmd_addr_i`), 1 indirect, 2 post-increment, 3 post-decrement, 4 post-add-step, 5 post-subtract-step, and 6 or 7 indexed with no update. In mode 6 the address is index register `cmd_idx_i` and the register is unchanged.
- R5: In modes 2 and 3 the access uses the old index value. The register then becomes that value plus or minus 1, modulo 1024.
- R6: In modes 4 and 5 the access uses the old index value. The register then becomes that value plus or minus its own step constant, modulo 1024.
- R7: An indirect command reads the word at `cmd_addr_i` at its first edge and holds `busy_o`=1 for the next cycle. At the second edge it performs the read or write at the low 10 bits of that word, and the upper bits are ignored.
- R8: A command presented while `busy_o`=1 is ignored: it causes no memory write and no index update.
- R9: At each completed access, `cmp_hit_o` is set to whether the effective address equals the limit, and `acc_addr_o` is set to the effective address. Both hold their values at every other edge, including the pointer fetch of an indirect command.
- R10: `set_sel_i` selects what the setup port loads: 0 an index register, 1 a step constant, 2 the limit, 3 nothing. A setup write to an index register overrides a post-modify of the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Access command present |
| cmd_write_i | input | 1 | 1 write, 0 read |
| cmd_mode_i | input | 3 | Addressing mode (R4) |
| cmd_idx_i | input | 4 | Index register select |
| cmd_addr_i | input | 10 | Direct address or pointer location |
| cmd_wdata_i | input | 16 | Write data |
| set_en_i | input | 1 | Setup write enable |
| set_sel_i | input | 2 | Setup target (R10) |
| set_idx_i | input | 4 | Setup register select |
| set_val_i | input | 10 | Setup value |
| busy_o | output | 1 | Indirect second phase in progress |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Read data |
| acc_addr_o | output | 10 | Effective address of last completed access |
| cmp_hit_o | output | 1 | Last effective address equals limit |

## Verification
The bench builds the block with its default parameters: 10 address bits, 16 data bits and 16 index registers. With these values an index register can be walked across the 1023-to-0 boundary in both directions, and a step of 30 from 1000 wraps to 6. A pointer word with its upper six bits set confirms that only the low address bits steer an indirect access. Sixteen registers give room to place a setup write and a post-modify on the same register in one cycle.

// File: rtl/dmem_agen_pkg.sv
package dmem_agen_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT    = 3'd0,
    AM_INDIRECT  = 3'd1,
    AM_POST_INC  = 3'd2,
    AM_POST_DEC  = 3'd3,
    AM_POST_ADD  = 3'd4,
    AM_POST_SUB  = 3'd5,
    AM_INDEX     = 3'd6,
    AM_INDEX_ALT = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SET_INDEX = 2'd0,
    SET_STEP  = 2'd1,
    SET_LIMIT = 2'd2,
    SET_NONE  = 2'd3
  } setsel_e;
endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] q_q;

  // q holds its value across writes
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      q_q <= mem_q[addr_i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dmem_idx_file.sv
module dmem_idx_file
  import dmem_agen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_IDX = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_IDX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  setsel_e           set_sel_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [ADDR_W-1:0] set_val_i,
  input  logic              upd_en_i,
  input  amode_e            upd_mode_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  output logic [ADDR_W-1:0] idx_val_o,
  output logic [ADDR_W-1:0] limit_o
);
  logic [NUM_IDX-1:0][ADDR_W-1:0] idx_q, idx_d, step_q, step_d;
  logic [ADDR_W-1:0] limit_q;

  function automatic logic [ADDR_W-1:0] post_mod(amode_e m, logic [ADDR_W-1:0] cur,
                                                logic [ADDR_W-1:0] stp);
    case (m)
      AM_POST_INC: return cur + ADDR_W'(1);
      AM_POST_DEC: return cur - ADDR_W'(1);
      AM_POST_ADD: return cur + stp;
      AM_POST_SUB: return cur - stp;
      default:     return cur;
    endcase
  endfunction

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_reg
    logic set_idx_hit, set_step_hit, upd_hit;
    assign set_idx_hit  = set_en_i && (set_sel_i == SET_INDEX) && (set_idx_i == IDX_W'(i));
    assign set_step_hit = set_en_i && (set_sel_i == SET_STEP) && (set_idx_i == IDX_W'(i));
    assign upd_hit      = upd_en_i && (upd_idx_i == IDX_W'(i));
    // setup load wins over post-modify
    assign idx_d[i]  = set_idx_hit ? set_val_i :
                       upd_hit ? post_mod(upd_mode_i, idx_q[i], step_q[i]) : idx_q[i];
    assign step_d[i] = set_step_hit ? set_val_i : step_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      step_q  <= '0;
      limit_q <= '0;
    end else begin
      idx_q  <= idx_d;
      step_q <= step_d;
      if (set_en_i && set_sel_i == SET_LIMIT) limit_q <= set_val_i;
    end
  end

  assign idx_val_o = idx_q[upd_idx_i];
  assign limit_o   = limit_q;

  AST_POST_INC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_mode_i == AM_POST_INC &&
     !(set_en_i && set_sel_i == SET_INDEX && set_idx_i == upd_idx_i))
    |=> idx_q[$past(upd_idx_i)] == ADDR_W'($past(idx_val_o) + ADDR_W'(1))); // R5

  AST_SETUP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && set_sel_i == SET_INDEX) |=> idx_q[$past(set_idx_i)] == $past(set_val_i)); // R10
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
  import dmem_agen_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  amode_e            cmd_mode_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [ADDR_W-1:0] idx_val_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic              upd_en_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              cmp_hit_o
);
  logic              ind_q, pend_we_q, cmp_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic              accept, fetch, is_post, use_cmd_addr;

  assign accept       = cmd_valid_i && !ind_q;
  assign fetch        = accept && (cmd_mode_i == AM_INDIRECT);
  assign is_post      = cmd_mode_i inside {AM_POST_INC, AM_POST_DEC, AM_POST_ADD, AM_POST_SUB};
  assign use_cmd_addr = cmd_mode_i inside {AM_DIRECT, AM_INDIRECT};
  assign upd_en_o     = accept && is_post;

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cmd_addr_i;
    mem_wdata_o = cmd_wdata_i;
    done_o      = 1'b0;
    if (ind_q) begin
      // second phase: pointer word sits in the RAM output register
      mem_en_o    = 1'b1;
      mem_we_o    = pend_we_q;
      mem_addr_o  = mem_q_i[ADDR_W-1:0];
      mem_wdata_o = pend_wdata_q;
      done_o      = 1'b1;
    end else if (accept) begin
      mem_en_o   = 1'b1;
      mem_we_o   = cmd_write_i && !fetch;
      mem_addr_o = use_cmd_addr ? cmd_addr_i : idx_val_i;
      done_o     = !fetch;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ind_q        <= 1'b0;
      pend_we_q    <= 1'b0;
      pend_wdata_q <= '0;
      acc_addr_q   <= '0;
      cmp_q        <= 1'b0;
    end else begin
      ind_q <= fetch;
      if (fetch) begin
        pend_we_q    <= cmd_write_i;
        pend_wdata_q <= cmd_wdata_i;
      end
      if (done_o) begin
        acc_addr_q <= mem_addr_o;
        cmp_q      <= (mem_addr_o == limit_i);
      end
    end
  end

  assign busy_o     = ind_q;
  assign acc_addr_o = acc_addr_q;
  assign cmp_hit_o  = cmp_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R7

  AST_BUSY_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !upd_en_o); // R8

  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(cmp_hit_o) && $stable(acc_addr_o)); // R9
endmodule

// File: rtl/dmem_agen.sv
module dmem_agen
  import dmem_agen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_IDX = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_IDX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [2:0]        cmd_mode_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              set_en_i,
  input  logic [1:0]        set_sel_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [ADDR_W-1:0] set_val_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              cmp_hit_o
);
  amode_e            mode;
  logic              upd_en, mem_en, mem_we, done, rvalid_q;
  logic [ADDR_W-1:0] idx_val, limit, mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_q;

  assign mode = amode_e'(cmd_mode_i);

  dmem_idx_file #(.ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX)) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (set_en_i),
    .set_sel_i  (setsel_e'(set_sel_i)),
    .set_idx_i  (set_idx_i),
    .set_val_i  (set_val_i),
    .upd_en_i   (upd_en),
    .upd_mode_i (mode),
    .upd_idx_i  (cmd_idx_i),
    .idx_val_o  (idx_val),
    .limit_o    (limit)
  );

  dmem_addr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_write_i (cmd_write_i),
    .cmd_mode_i  (mode),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .idx_val_i   (idx_val),
    .limit_i     (limit),
    .mem_q_i     (mem_q),
    .upd_en_o    (upd_en),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .busy_o      (busy_o),
    .done_o      (done),
    .acc_addr_o  (acc_addr_o),
    .cmp_hit_o   (cmp_hit_o)
  );

  dmem_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .q_o     (mem_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= done && !mem_we;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = mem_q;

  AST_RVALID_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(mem_en && !mem_we)); // R3

  AST_WRITE_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && mem_we) |=> !rvalid_o); // R3
endmodule

// File: tb/sim_dmem_agen.sv
`timescale 1ns/1ps
module sim_dmem_agen;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NUM_IDX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [2:0]  cmd_mode = 3'd0;
  logic [3:0]  cmd_idx = 4'd0;
  logic [9:0]  cmd_addr = 10'd0;
  logic [15:0] cmd_wdata = 16'd0;
  logic        set_en = 1'b0;
  logic [1:0]  set_sel = 2'd3;
  logic [3:0]  set_idx = 4'd0;
  logic [9:0]  set_val = 10'd0;
  logic        busy, rvalid, cmp_hit;
  logic [15:0] rdata;
  logic [9:0]  acc_addr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmem_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IDX(NUM_IDX)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_mode_i(cmd_mode),
    .cmd_idx_i(cmd_idx), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .set_en_i(set_en), .set_sel_i(set_sel), .set_idx_i(set_idx), .set_val_i(set_val),
    .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .acc_addr_o(acc_addr), .cmp_hit_o(cmp_hit)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // presents one command for one edge, then checks happen after that edge
  task automatic cmd(bit wr, logic [2:0] m, logic [3:0] ix, logic [9:0] a, logic [15:0] wd);
    cmd_valid = 1'b1; cmd_write = wr; cmd_mode = m; cmd_idx = ix;
    cmd_addr = a; cmd_wdata = wd;
    tick();
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic setup(logic [1:0] s, logic [3:0] ix, logic [9:0] v);
    set_en = 1'b1; set_sel = s; set_idx = ix; set_val = v;
    tick();
    set_en = 1'b0; set_sel = 2'd3;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "rvalid", rvalid, 0);
    chk("R1", "cmp_hit", cmp_hit, 0);
    chk("R1", "acc_addr", acc_addr, 0);
    cmd(0, 3'd0, 0, 10'd7, 0);
    chk("R1", "direct acc_addr", acc_addr, 7);
    cmd(0, 3'd6, 4'd9, 10'd0, 0);
    chk("R1", "index reg 9 reset", acc_addr, 0);
    chk("R1", "limit reset gives hit at 0", cmp_hit, 1);
  endtask

  task automatic t_direct();
    cmd(1, 3'd0, 0, 10'd100, 16'h1234);
    chk("R3", "no rvalid on write", rvalid, 0);
    cmd(1, 3'd0, 0, 10'd101, 16'hBEEF);
    chk("R3", "no rvalid on write 2", rvalid, 0);
    cmd(0, 3'd0, 0, 10'd100, 0);
    chk("R2", "rvalid", rvalid, 1);
    chk("R2", "rdata 100", rdata, 16'h1234);
    cmd(0, 3'd0, 0, 10'd101, 0);
    chk("R3", "back to back rvalid", rvalid, 1);
    chk("R3", "back to back rdata", rdata, 16'hBEEF);
    tick();
    chk("R2", "rvalid drops when idle", rvalid, 0);
  endtask

  task automatic t_index();
    setup(2'd0, 4'd3, 10'd100);
    cmd(0, 3'd6, 4'd3, 0, 0);
    chk("R4", "index addr", acc_addr, 100);
    chk("R4", "index data", rdata, 16'h1234);
    cmd(0, 3'd7, 4'd3, 0, 0);
    chk("R4", "index unchanged", acc_addr, 100);
  endtask

  task automatic t_inc_dec();
    setup(2'd0, 4'd4, 10'd1023);
    cmd(0, 3'd2, 4'd4, 0, 0);
    chk("R5", "inc uses old", acc_addr, 1023);
    cmd(0, 3'd6, 4'd4, 0, 0);
    chk("R5", "inc wraps to 0", acc_addr, 0);
    cmd(0, 3'd3, 4'd4, 0, 0);
    chk("R5", "dec uses old", acc_addr, 0);
    cmd(0, 3'd6, 4'd4, 0, 0);
    chk("R5", "dec wraps to 1023", acc_addr, 1023);
  endtask

  task automatic t_step();
    setup(2'd0, 4'd5, 10'd1000);
    setup(2'd1, 4'd5, 10'd30);
    cmd(1, 3'd4, 4'd5, 0, 16'hA5A5);
    chk("R6", "add uses old", acc_addr, 1000);
    cmd(0, 3'd6, 4'd5, 0, 0);
    chk("R6", "add wraps to 6", acc_addr, 6);
    cmd(0, 3'd5, 4'd5, 0, 0);
    chk("R6", "sub uses old", acc_addr, 6);
    cmd(0, 3'd6, 4'd5, 0, 0);
    chk("R6", "sub wraps back", acc_addr, 1000);
    chk("R6", "data written via add", rdata, 16'hA5A5);
  endtask

  task automatic t_indirect();
    cmd(1, 3'd0, 0, 10'd200, 16'hFC64);   // low 10 bits = 100
    cmd(0, 3'd1, 0, 10'd200, 0);
    chk("R7", "busy after fetch", busy, 1);
    chk("R7", "no rvalid on fetch", rvalid, 0);
    tick();
    chk("R7", "busy cleared", busy, 0);
    chk("R7", "rvalid", rvalid, 1);
    chk("R7", "rdata via pointer", rdata, 16'h1234);
    chk("R7", "acc_addr low bits", acc_addr, 100);
    cmd(1, 3'd0, 0, 10'd201, 16'h0066);   // points to 102
    cmd(1, 3'd1, 0, 10'd201, 16'h5A5A);
    tick();
    chk("R7", "indirect write no rvalid", rvalid, 0);
    cmd(0, 3'd0, 0, 10'd102, 0);
    chk("R7", "indirect write landed", rdata, 16'h5A5A);
  endtask

  task automatic t_busy_ignore();
    cmd(1, 3'd0, 0, 10'd300, 16'h1111);
    setup(2'd0, 4'd7, 10'd50);
    cmd(0, 3'd1, 0, 10'd200, 0);
    // stimulus during busy cycle
    cmd(1, 3'd0, 0, 10'd300, 16'hDEAD);
    chk("R8", "indirect still completes", rdata, 16'h1234);
    cmd(0, 3'd1, 0, 10'd200, 0);
    cmd(0, 3'd2, 4'd7, 0, 0);
    cmd(0, 3'd0, 0, 10'd300, 0);
    chk("R8", "write during busy dropped", rdata, 16'h1111);
    cmd(0, 3'd6, 4'd7, 0, 0);
    chk("R8", "inc during busy dropped", acc_addr, 50);
  endtask

  task automatic t_cmp();
    setup(2'd2, 0, 10'd100);
    cmd(0, 3'd0, 0, 10'd100, 0);
    chk("R9", "hit on limit", cmp_hit, 1);
    cmd(0, 3'd0, 0, 10'd101, 0);
    chk("R9", "miss", cmp_hit, 0);
    cmd(1, 3'd0, 0, 10'd100, 16'h1234);
    chk("R9", "hit on write", cmp_hit, 1);
    cmd(0, 3'd0, 0, 10'd101, 0);
    cmd(0, 3'd1, 0, 10'd200, 0);
    chk("R9", "hold during fetch", cmp_hit, 0);
    chk("R9", "acc_addr hold during fetch", acc_addr, 101);
    tick();
    chk("R9", "hit via indirect", cmp_hit, 1);
  endtask

  task automatic t_collide();
    setup(2'd0, 4'd6, 10'd10);
    set_en = 1'b1; set_sel = 2'd0; set_idx = 4'd6; set_val = 10'd500;
    cmd(0, 3'd2, 4'd6, 0, 0);
    set_en = 1'b0; set_sel = 2'd3;
    chk("R10", "access uses old", acc_addr, 10);
    cmd(0, 3'd6, 4'd6, 0, 0);
    chk("R10", "setup wins", acc_addr, 500);
    setup(2'd3, 4'd6, 10'd77);
    cmd(0, 3'd6, 4'd6, 0, 0);
    chk("R10", "select 3 loads nothing", acc_addr, 500);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_direct();
    t_index();
    t_inc_dec();
    t_step();
    t_indirect();
    t_busy_ignore();
    t_cmp();
    t_collide();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule